// File: doc/BRIEF.md
# Station Address Receive Filter

This block decides, for each incoming frame, whether the frame is kept or dropped. It watches the byte stream of a receive path and keeps the first six bytes, which form the 48-bit destination address. When the sixth byte arrives, it compares that address with a programmed station address and with a set of acceptance enables. It then reports an early verdict. When the frame ends, it checks the error and runt flags against two acceptance options and gives a final verdict.

Software programs the station address through a pair of registers. The first is an index/control register. Its low bits select which half-word the next data write updates, and its upper bits hold the acceptance enables. The second is a data register, which takes one 16-bit half of the station address per write. A separate receive-option write sets whether errored frames and runt frames are kept. A frame counts as broadcast when all 48 destination bits are one. It counts as group (multicast) when bit 0 of the first destination byte is one, and as unicast otherwise. Hash-based specific-multicast filtering is not built. Its enable is stored and shown on an output pin, but it never produces a match.

Top module: `stn_rx_filter`

## Requirements
- R1: A write with `cfg_sel`=0 loads the index from `cfg_wdata[9:0]` and the enables from the upper bits: broadcast is enabled only when bits 31 and 30 are both 1, bit 29 is all-group, bit 28 is all-unicast, bit 27 is station match, and bit 21 is specific-multicast. Bit 21 appears on `mcast_filt_en` the cycle after the write.
- R2: A write with `cfg_sel`=1 stores `cfg_wdata[15:0]` when the current index is 0, 2 or 4. Bits 7:0 become address byte 2k and bits 15:8 become byte 2k+1, where k is index/2 and byte 0 is the first byte on the wire. A data write at any other index changes nothing.
- R3: With the station-match enable set, a unicast frame whose destination equals the station address is accepted, and any other unicast destination is rejected.
- R4: An all-ones destination is accepted by the broadcast enable only when bits 31:30 were both written as 1. Setting only one of them does not accept broadcast.
- R5: The all-group enable accepts every destination with bit 0 of its first byte set, broadcast included. It accepts no unicast frame.
- R6: The all-unicast enable accepts every unicast destination whatever the station address, and accepts no group destination.
- R7: The specific-multicast enable alone never accepts a frame.
- R8: `dec_valid` pulses for one cycle, in the cycle after the sixth byte of a frame (the first byte is marked by `rx_sof`). `dec_accept` carries the verdict from that cycle and holds it until the next `rx_sof`.
- R9: `fin_valid` pulses in the cycle after `rx_eof`, and `fin_accept` is 1 only while `fin_valid` is 1. A frame that ends before its sixth byte gives no `dec_valid` and a final reject.
- R10: A receive-option write sets error acceptance from bit 5 and runt acceptance from bit 4. An accepted frame whose end carries `rx_err` or `rx_runt` has a final reject unless the matching option is set.
- R11: Reset clears the station address, the index, all enables, both options and all verdict outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = index/control register, 1 = address data register |
| cfg_wdata | input | 32 | Register write data |
| rxopt_wr_en | input | 1 | Receive-option write strobe |
| rxopt_wdata | input | 32 | Receive-option data (bit 5 error, bit 4 runt) |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_byte | input | 8 | Receive byte |
| rx_eof | input | 1 | End-of-frame strobe |
| rx_err | input | 1 | Frame error flag, sampled with rx_eof |
| rx_runt | input | 1 | Runt frame flag, sampled with rx_eof |
| dec_valid | output | 1 | Early verdict strobe |
| dec_accept | output | 1 | Early verdict, held within the frame |
| fin_valid | output | 1 | Final verdict strobe |
| fin_accept | output | 1 | Final verdict |
| mcast_filt_en | output | 1 | Stored specific-multicast enable |

## Verification
Two cases are hard to reach from the ports. One is an early accept that the end-of-frame rules later turn into a reject. The other is a data write that must leave no trace. For the first, the stimulus table pairs matched destinations with error and runt flags under each option setting, including the case where only the option that does not apply is set. For the second, directed writes at odd and out-of-range indices are followed by a station-address frame, which must still be accepted, and an overwrite at index 2 then shows the byte order inside a half-word.

// File: rtl/stn_filt_pkg.sv
package stn_filt_pkg;

    // Positions of the enables in the index/control word
    localparam int unsigned BIT_BCAST_HI = 31;
    localparam int unsigned BIT_BCAST_LO = 30;
    localparam int unsigned BIT_ALLGRP   = 29;
    localparam int unsigned BIT_ALLUNI   = 28;
    localparam int unsigned BIT_STN      = 27;
    localparam int unsigned BIT_HASH     = 21;

    // Positions of the options in the receive-option word
    localparam int unsigned BIT_OPT_ERR  = 5;
    localparam int unsigned BIT_OPT_RUNT = 4;

    typedef struct packed {
        logic bcast_en;
        logic allgrp_en;
        logic alluni_en;
        logic stn_en;
        logic hash_en;
    } mode_t;

endpackage

// File: rtl/stn_filt_regs.sv
module stn_filt_regs
    import stn_filt_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned IDX_W      = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr_en,
    input  logic                          cfg_sel,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic                          rxopt_wr_en,
    input  logic [DATA_W-1:0]             rxopt_wdata,
    output logic [ADDR_BYTES-1:0][7:0]    sta_addr,
    output mode_t                         mode,
    output logic                          acc_err,
    output logic                          acc_runt
);
    localparam int unsigned NUM_HALVES = ADDR_BYTES / 2;

    typedef struct packed {
        logic [IDX_W-1:0]              idx;
        mode_t                         mode;
        logic [ADDR_BYTES-1:0][7:0]    sta;
        logic                          acc_err;
        logic                          acc_runt;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr_en && !cfg_sel) begin
            regs_d.idx            = cfg_wdata[IDX_W-1:0];
            regs_d.mode.bcast_en  = cfg_wdata[BIT_BCAST_HI] & cfg_wdata[BIT_BCAST_LO];
            regs_d.mode.allgrp_en = cfg_wdata[BIT_ALLGRP];
            regs_d.mode.alluni_en = cfg_wdata[BIT_ALLUNI];
            regs_d.mode.stn_en    = cfg_wdata[BIT_STN];
            regs_d.mode.hash_en   = cfg_wdata[BIT_HASH];
        end else if (cfg_wr_en && cfg_sel) begin
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (regs_q.idx == IDX_W'(2 * h)) begin
                    regs_d.sta[2*h]   = cfg_wdata[7:0];
                    regs_d.sta[2*h+1] = cfg_wdata[15:8];
                end
            end
        end
        if (rxopt_wr_en) begin
            regs_d.acc_err  = rxopt_wdata[BIT_OPT_ERR];
            regs_d.acc_runt = rxopt_wdata[BIT_OPT_RUNT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign sta_addr = regs_q.sta;
    assign mode     = regs_q.mode;
    assign acc_err  = regs_q.acc_err;
    assign acc_runt = regs_q.acc_runt;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[DATA_W-1:IDX_W], rxopt_wdata};
endmodule

// File: rtl/stn_filt_decide.sv
module stn_filt_decide
    import stn_filt_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic [ADDR_BYTES-1:0][7:0] dest,
    input  logic [ADDR_BYTES-1:0][7:0] sta_addr,
    input  mode_t                      mode,
    output logic                       accept
);
    logic [ADDR_BYTES-1:0] byte_ones;
    logic [ADDR_BYTES-1:0] byte_eq;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign byte_ones[g] = &dest[g];
        assign byte_eq[g]   = (dest[g] == sta_addr[g]);
    end

    logic is_bcast, is_group, stn_hit;
    assign is_bcast = &byte_ones;
    assign is_group = dest[0][0];
    assign stn_hit  = &byte_eq;

    // Specific-multicast hashing is not built: hash_en never matches.
    assign accept = (is_bcast && mode.bcast_en)
                  || (is_group && mode.allgrp_en)
                  || (!is_group && mode.alluni_en)
                  || (!is_group && mode.stn_en && stn_hit);

    logic unused_hash;
    assign unused_hash = mode.hash_en;
endmodule

// File: rtl/stn_filt_capture.sv
module stn_filt_capture #(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic                       rx_sof,
    input  logic [7:0]                 rx_byte,
    input  logic                       rx_eof,
    input  logic                       rx_err,
    input  logic                       rx_runt,
    input  logic                       acc_err,
    input  logic                       acc_runt,
    input  logic                       addr_accept,
    output logic [ADDR_BYTES-1:0][7:0] dest,
    output logic                       dec_valid,
    output logic                       dec_accept,
    output logic                       fin_valid,
    output logic                       fin_accept
);
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
    localparam int unsigned LAST  = ADDR_BYTES - 1;

    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [ADDR_BYTES-2:0][7:0]    bytes;
        logic                          decided;
        logic                          dec_acc;
        logic                          dec_vld;
        logic                          fin_vld;
        logic                          fin_acc;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [CNT_W-1:0] pos;

    assign pos = rx_sof ? '0 : cap_q.cnt;

    always_comb begin
        for (int i = 0; i < ADDR_BYTES - 1; i++) dest[i] = cap_q.bytes[i];
        dest[LAST] = rx_byte;
    end

    always_comb begin
        cap_d         = cap_q;
        cap_d.dec_vld = 1'b0;
        cap_d.fin_vld = 1'b0;
        cap_d.fin_acc = 1'b0;
        if (rx_valid) begin
            if (rx_sof) begin
                cap_d.decided = 1'b0;
                cap_d.dec_acc = 1'b0;
            end
            if (pos < CNT_W'(LAST)) begin
                cap_d.bytes[pos] = rx_byte;
                cap_d.cnt        = pos + 1'b1;
            end else if (pos == CNT_W'(LAST)) begin
                cap_d.cnt     = pos + 1'b1;
                cap_d.decided = 1'b1;
                cap_d.dec_vld = 1'b1;
                cap_d.dec_acc = addr_accept;
            end
        end
        if (rx_eof) begin
            cap_d.fin_vld = 1'b1;
            cap_d.fin_acc = cap_q.decided && cap_q.dec_acc
                          && (!rx_err || acc_err) && (!rx_runt || acc_runt);
            cap_d.decided = 1'b0;
            cap_d.cnt     = CNT_W'(ADDR_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_q.cnt <= CNT_W'(ADDR_BYTES);
        end else begin
            cap_q <= cap_d;
        end
    end

    assign dec_valid  = cap_q.dec_vld;
    assign dec_accept = cap_q.dec_acc;
    assign fin_valid  = cap_q.fin_vld;
    assign fin_accept = cap_q.fin_acc;
endmodule

// File: rtl/stn_rx_filter.sv
module stn_rx_filter
    import stn_filt_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rxopt_wr_en,
    input  logic [DATA_W-1:0] rxopt_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic              rx_runt,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              fin_valid,
    output logic              fin_accept,
    output logic              mcast_filt_en
);
    logic [ADDR_BYTES-1:0][7:0] sta_addr;
    logic [ADDR_BYTES-1:0][7:0] dest;
    mode_t                      mode;
    logic                       cfg_acc_err;
    logic                       cfg_acc_runt;
    logic                       addr_accept;

    stn_filt_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .rxopt_wr_en (rxopt_wr_en),
        .rxopt_wdata (rxopt_wdata),
        .sta_addr    (sta_addr),
        .mode        (mode),
        .acc_err     (cfg_acc_err),
        .acc_runt    (cfg_acc_runt)
    );

    stn_filt_decide #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_decide (
        .dest     (dest),
        .sta_addr (sta_addr),
        .mode     (mode),
        .accept   (addr_accept)
    );

    stn_filt_capture #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_byte     (rx_byte),
        .rx_eof      (rx_eof),
        .rx_err      (rx_err),
        .rx_runt     (rx_runt),
        .acc_err     (cfg_acc_err),
        .acc_runt    (cfg_acc_runt),
        .addr_accept (addr_accept),
        .dest        (dest),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept),
        .fin_valid   (fin_valid),
        .fin_accept  (fin_accept)
    );

    assign mcast_filt_en = mode.hash_en;
endmodule

// File: rtl/stn_rx_filter_chk.sv
module stn_rx_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_eof,
    input logic rx_err,
    input logic rx_runt,
    input logic acc_err,
    input logic acc_runt,
    input logic dec_valid,
    input logic dec_accept,
    input logic fin_valid,
    input logic fin_accept
);
    a_r9_fin_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |=> fin_valid);

    a_r9_fin_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |-> $past(rx_eof));

    a_r9_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        fin_accept |-> fin_valid);

    a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && rx_err && !acc_err) |=> !fin_accept);

    a_r10_runt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && rx_runt && !acc_runt) |=> !fin_accept);

    a_r8_dec_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    a_r8_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(dec_accept));
endmodule

bind stn_rx_filter stn_rx_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_eof     (rx_eof),
    .rx_err     (rx_err),
    .rx_runt    (rx_runt),
    .acc_err    (cfg_acc_err),
    .acc_runt   (cfg_acc_runt),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .fin_valid  (fin_valid),
    .fin_accept (fin_accept)
);

// File: tb/stn_rx_filter_tb.sv
module stn_rx_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        rxopt_wr_en = 1'b0;
    logic [31:0] rxopt_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_eof = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_runt = 1'b0;
    logic        dec_valid, dec_accept, fin_valid, fin_accept, mcast_filt_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    stn_rx_filter dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
        .rxopt_wr_en (rxopt_wr_en), .rxopt_wdata (rxopt_wdata),
        .rx_valid (rx_valid), .rx_sof (rx_sof), .rx_byte (rx_byte),
        .rx_eof (rx_eof), .rx_err (rx_err), .rx_runt (rx_runt),
        .dec_valid (dec_valid), .dec_accept (dec_accept),
        .fin_valid (fin_valid), .fin_accept (fin_accept),
        .mcast_filt_en (mcast_filt_en)
    );

    localparam logic [47:0] STN   = 48'h0211_2233_4455;
    localparam logic [47:0] OTHER = 48'h0211_2233_4456;
    localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] GRP   = 48'h0100_5E00_0001;
    localparam logic [31:0] M_STN = 32'h0800_0000;
    localparam logic [31:0] M_BC  = 32'hC000_0000;
    localparam logic [31:0] M_HBC = 32'h4000_0000;
    localparam logic [31:0] M_GRP = 32'h2000_0000;
    localparam logic [31:0] M_UNI = 32'h1000_0000;
    localparam logic [31:0] M_HSH = 32'h0020_0000;

    typedef struct packed {
        logic [31:0] mode;
        logic [47:0] dest;
        logic        err;
        logic        runt;
        logic        opt_err;
        logic        opt_runt;
        logic        exp_dec;
        logic        exp_fin;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{M_STN, STN,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 hit
        '{M_STN, OTHER, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 miss
        '{M_BC,  BC,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R4
        '{M_HBC, BC,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 one bit only
        '{M_STN, BC,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 broadcast not station
        '{M_GRP, GRP,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5
        '{M_GRP, BC,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 broadcast is group
        '{M_GRP, STN,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 unicast
        '{M_UNI, OTHER, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R6
        '{M_UNI, GRP,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 group
        '{M_HSH, GRP,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R7
        '{M_STN, STN,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 err dropped
        '{M_STN, STN,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R10 err kept
        '{M_STN, STN,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 runt dropped
        '{M_STN, STN,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R10 runt kept
        '{M_STN, STN,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R10 wrong option
        '{M_BC,  OTHER, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R4 unicast
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_wr_en = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    endtask

    task automatic opt_write(input logic e, input logic r);
        rxopt_wr_en = 1'b1; rxopt_wdata = {26'd0, e, r, 4'd0};
        tick();
        rxopt_wr_en = 1'b0; rxopt_wdata = '0;
    endtask

    task automatic load_station(input logic [47:0] a);
        cfg_write(1'b0, 32'd0); cfg_write(1'b1, {16'd0, a[39:32], a[47:40]});
        cfg_write(1'b0, 32'd2); cfg_write(1'b1, {16'd0, a[23:16], a[31:24]});
        cfg_write(1'b0, 32'd4); cfg_write(1'b1, {16'd0, a[7:0],   a[15:8]});
    endtask

    // Sends nbytes of a frame starting with dest, then an end strobe.
    task automatic send_frame(input logic [47:0] dest, input int nbytes,
                              input logic e, input logic r,
                              output logic dv, output logic da,
                              output logic fv, output logic fa);
        dv = 1'b0; da = 1'b0;
        for (int i = 0; i < nbytes; i++) begin
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_byte  = (i < 6) ? dest[47 - 8*i -: 8] : 8'(8'hA0 + i);
            tick();
            if (i == 5) begin dv = dec_valid; da = dec_accept; end
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = '0;
        rx_eof = 1'b1; rx_err = e; rx_runt = r;
        tick();
        fv = fin_valid; fa = fin_accept;
        rx_eof = 1'b0; rx_err = 1'b0; rx_runt = 1'b0;
        tick();
    endtask

    initial begin
        logic dv, da, fv, fa;
        repeat (3) tick();
        check("R11 reset dec_valid", 32'(dec_valid), 32'd0);
        check("R11 reset fin_valid", 32'(fin_valid), 32'd0);
        check("R11 reset mcast_filt_en", 32'(mcast_filt_en), 32'd0);
        rst_n = 1'b1;
        tick();

        load_station(STN);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            opt_write(VECS[v].opt_err, VECS[v].opt_runt);
            cfg_write(1'b0, VECS[v].mode);
            send_frame(VECS[v].dest, 10, VECS[v].err, VECS[v].runt, dv, da, fv, fa);
            check($sformatf("R8 vec%0d dec_valid", v), 32'(dv), 32'd1);
            check($sformatf("R3-R7 vec%0d dec_accept", v), 32'(da), 32'(VECS[v].exp_dec));
            check($sformatf("R9 vec%0d fin_valid", v), 32'(fv), 32'd1);
            check($sformatf("R10 vec%0d fin_accept", v), 32'(fa), 32'(VECS[v].exp_fin));
        end
        opt_write(1'b0, 1'b0);

        // R1: specific-multicast enable reported
        cfg_write(1'b0, M_HSH);
        check("R1 mcast_filt_en set", 32'(mcast_filt_en), 32'd1);
        cfg_write(1'b0, M_STN);
        check("R1 mcast_filt_en clear", 32'(mcast_filt_en), 32'd0);

        // R2: writes at indices 1, 3, 6 are ignored
        cfg_write(1'b0, M_STN | 32'd1); cfg_write(1'b1, 32'h0000_FFFF);
        cfg_write(1'b0, M_STN | 32'd3); cfg_write(1'b1, 32'h0000_FFFF);
        cfg_write(1'b0, M_STN | 32'd6); cfg_write(1'b1, 32'h0000_FFFF);
        send_frame(STN, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R2 ignored index keeps address", 32'(fa), 32'd1);

        // R2: byte order inside a half-word (index 2 -> bytes 2,3)
        cfg_write(1'b0, M_STN | 32'd2); cfg_write(1'b1, 32'h0000_BBAA);
        send_frame(48'h0211_AABB_4455, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R2 new half accepted", 32'(fa), 32'd1);
        send_frame(48'h0211_BBAA_4455, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R2 swapped half rejected", 32'(fa), 32'd0);
        send_frame(STN, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R2 old half rejected", 32'(fa), 32'd0);

        // R8: verdict holds after the end of frame
        cfg_write(1'b0, M_UNI);
        send_frame(OTHER, 8, 1'b0, 1'b0, dv, da, fv, fa);
        repeat (4) tick();
        check("R8 dec_accept held", 32'(dec_accept), 32'd1);
        check("R8 dec_valid single pulse", 32'(dec_valid), 32'd0);

        // R9: short frame gets no early verdict and a final reject
        send_frame(OTHER, 3, 1'b0, 1'b0, dv, da, fv, fa);
        check("R9 short no dec_valid", 32'(dv), 32'd0);
        check("R9 short fin_valid", 32'(fv), 32'd1);
        check("R9 short fin_accept", 32'(fa), 32'd0);
        check("R9 fin_accept low between frames", 32'(fin_accept), 32'd0);

        // R11: reset clears station address and enables
        cfg_write(1'b0, M_HSH | M_STN);
        rst_n = 1'b0; tick(); tick();
        check("R11 mcast_filt_en cleared", 32'(mcast_filt_en), 32'd0);
        check("R11 dec_accept cleared", 32'(dec_accept), 32'd0);
        rst_n = 1'b1; tick();
        send_frame(48'h0, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R11 enables cleared", 32'(fa), 32'd0);
        cfg_write(1'b0, M_STN);
        send_frame(48'h0, 8, 1'b0, 1'b0, dv, da, fv, fa);
        check("R11 address cleared to zero", 32'(fa), 32'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule